// File: doc/BRIEF.md
# Streaming Edge Port Handshake Controller

This controller owns a single streaming edge between a producer task port and the input port of a child task that runs on another core. When a producer beat first shows up, the controller raises a start request toward the child. The request carries the producer port identity. The request is held and retried every cycle until the task currently on the consumer core has finished and the consumer port is free. The grant then does three things in one cycle: it sets the port's busy flag, it marks the child task ready, and it returns a start acknowledgement.

After the grant, producer beats flow straight to the consumer port. The controller counts the bytes moved against the total length the producer supplied with its first beat. When that total is reached, the controller emits a one-cycle end-of-stream message, and that message releases the port. A zero length closes the stream at once, with no beats moved. Each grant also yields a child task tag equal to the producer instance number plus a dependence distance, so a producer instance is linked to the child instance that many tasks later.

The handshake walks five named states. IDLE waits for producer data and goes to REQUEST. REQUEST holds the start request and goes to GRANT on a grant. GRANT lasts one cycle and goes to CLOSE for a zero length, otherwise to STREAM. STREAM passes beats and goes to CLOSE when the last beat is accepted. CLOSE lasts one cycle, sends end-of-stream and returns to IDLE.

Top module: `stream_port_hs`

## Requirements
- R1: After reset the controller is in IDLE. In IDLE, start_req, start_ack, child_ready, port_busy, prod_ready, cons_valid and eos are all 0.
- R2: A prod_valid seen in IDLE raises start_req on the next cycle. start_req_port carries the prod_port_id captured at that moment and holds it while the request is pending.
- R3: A pending request is granted only in a cycle where cons_task_done is 1 and the port is not busy. Otherwise start_req stays high every cycle and no acknowledgement is given.
- R4: The grant produces exactly one cycle in which start_ack and child_ready are both 1. port_busy reads 1 from that cycle on.
- R5: Before the grant, prod_ready and cons_valid stay 0, so the producer is held back.
- R6: While streaming, cons_valid follows prod_valid, cons_data equals prod_data, and prod_ready follows cons_ready. A beat moves in a cycle where prod_valid and cons_ready are both 1.
- R7: Each accepted beat counts as BEAT_BYTES bytes, or as the remaining bytes if fewer remain. The stream accepts exactly ceil(len/BEAT_BYTES) beats. eos is high for the one cycle after the last beat, and never earlier.
- R8: port_busy stays 1 through the eos cycle and is 0 in the cycle after eos.
- R9: A length of 0 gives the eos cycle directly after the grant cycle, and no beat is accepted.
- R10: child_tag, valid while child_ready is 1, equals (k + dep_dist) mod 2^TAG_W. Here k is the number of grants since reset and dep_dist is captured with the first producer beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_valid | input | 1 | Producer beat present |
| prod_ready | output | 1 | Producer beat accepted |
| prod_data | input | DATA_W | Producer beat payload |
| prod_len | input | LEN_W | Total stream bytes, sampled with the first beat |
| prod_port_id | input | PID_W | Producer port identity, sampled with the first beat |
| dep_dist | input | TAG_W | Dependence distance, sampled with the first beat |
| cons_task_done | input | 1 | Task occupying the consumer core has finished |
| start_req | output | 1 | Start request toward the child |
| start_req_port | output | PID_W | Producer port carried by the request |
| start_ack | output | 1 | Start acknowledgement (one cycle) |
| child_ready | output | 1 | Child task marked ready (one cycle) |
| child_tag | output | TAG_W | Child instance linked by the dependence distance |
| port_busy | output | 1 | Consumer port acquired |
| cons_valid | output | 1 | Beat offered to the consumer port |
| cons_ready | input | 1 | Consumer port accepts a beat |
| cons_data | output | DATA_W | Beat payload to the consumer |
| eos | output | 1 | End-of-stream message (one cycle) |

## Verification
Streams are run with lengths that are a whole number of beats, a partial last beat, a single byte and zero bytes, which separates correct rounding of the final beat from an off-by-one close. Grant waits of zero to three cycles check that the request is retried without loss. Streams alternate between steady and stalling consumer readiness, which shows that beats are counted only when accepted. The dependence distance is varied, including a value that wraps the tag, which checks that the tag comes from the grant count and not from the stream index.

// File: rtl/sphs_pkg.sv
package sphs_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_REQUEST = 3'd1,
        S_GRANT   = 3'd2,
        S_STREAM  = 3'd3,
        S_CLOSE   = 3'd4
    } hs_state_e;
endpackage

// File: rtl/sphs_busy_flag.sv
module sphs_busy_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic acquire,
    input  logic release_port,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (!rst_n)            busy <= 1'b0;
        else if (acquire)      busy <= 1'b1;
        else if (release_port) busy <= 1'b0;
    end
endmodule

// File: rtl/sphs_byte_ctr.sv
module sphs_byte_ctr #(
    parameter int LEN_W      = 16,
    parameter int BEAT_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             beat,
    output logic             len_zero,
    output logic             last_beat
);
    localparam logic [LEN_W-1:0] BEAT_L = LEN_W'(BEAT_BYTES);

    logic [LEN_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_len;
        end else if (beat) begin
            if (remaining > BEAT_L) remaining <= remaining - BEAT_L;
            else                    remaining <= '0;
        end
    end

    assign len_zero  = (remaining == '0);
    assign last_beat = (remaining <= BEAT_L);
endmodule

// File: rtl/sphs_fsm.sv
module sphs_fsm
    import sphs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      prod_valid,
    input  logic      grant_ok,
    input  logic      len_zero,
    input  logic      beat_fire,
    input  logic      last_beat,
    output hs_state_e state
);
    hs_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (prod_valid) state_nx = S_REQUEST;
            S_REQUEST: if (grant_ok)   state_nx = S_GRANT;
            S_GRANT:   state_nx = len_zero ? S_CLOSE : S_STREAM;
            S_STREAM:  if (beat_fire && last_beat) state_nx = S_CLOSE;
            S_CLOSE:   state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end
endmodule

// File: rtl/stream_port_hs.sv
module stream_port_hs
    import sphs_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int LEN_W      = 16,
    parameter int PID_W      = 4,
    parameter int TAG_W      = 4,
    parameter int BEAT_BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prod_valid,
    output logic              prod_ready,
    input  logic [DATA_W-1:0] prod_data,
    input  logic [LEN_W-1:0]  prod_len,
    input  logic [PID_W-1:0]  prod_port_id,
    input  logic [TAG_W-1:0]  dep_dist,
    input  logic              cons_task_done,
    output logic              start_req,
    output logic [PID_W-1:0]  start_req_port,
    output logic              start_ack,
    output logic              child_ready,
    output logic [TAG_W-1:0]  child_tag,
    output logic              port_busy,
    output logic              cons_valid,
    input  logic              cons_ready,
    output logic [DATA_W-1:0] cons_data,
    output logic              eos
);
    hs_state_e        state;
    logic             grant_ok;
    logic             len_zero;
    logic             last_beat;
    logic             beat_fire;
    logic             capture;
    logic [TAG_W-1:0] inst_cnt;
    logic [PID_W-1:0] port_q;
    logic [TAG_W-1:0] tag_q;

    assign capture   = (state == S_IDLE) && prod_valid;
    assign grant_ok  = (state == S_REQUEST) && cons_task_done && !port_busy;
    assign beat_fire = (state == S_STREAM) && prod_valid && cons_ready;

    sphs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .prod_valid (prod_valid),
        .grant_ok   (grant_ok),
        .len_zero   (len_zero),
        .beat_fire  (beat_fire),
        .last_beat  (last_beat),
        .state      (state)
    );

    sphs_byte_ctr #(.LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (capture),
        .load_len  (prod_len),
        .beat      (beat_fire),
        .len_zero  (len_zero),
        .last_beat (last_beat)
    );

    sphs_busy_flag u_busy (
        .clk          (clk),
        .rst_n        (rst_n),
        .acquire      (grant_ok),
        .release_port (state == S_CLOSE),
        .busy         (port_busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inst_cnt <= '0;
            port_q   <= '0;
            tag_q    <= '0;
        end else begin
            if (capture) begin
                port_q <= prod_port_id;
                tag_q  <= inst_cnt + dep_dist;
            end
            if (grant_ok) inst_cnt <= inst_cnt + 1'b1;
        end
    end

    always_comb begin
        start_req      = 1'b0;
        start_ack      = 1'b0;
        child_ready    = 1'b0;
        prod_ready     = 1'b0;
        cons_valid     = 1'b0;
        eos            = 1'b0;
        unique case (state)
            S_IDLE:    ;
            S_REQUEST: start_req = 1'b1;
            S_GRANT: begin
                start_ack   = 1'b1;
                child_ready = 1'b1;
            end
            S_STREAM: begin
                prod_ready = cons_ready;
                cons_valid = prod_valid;
            end
            S_CLOSE:   eos = 1'b1;
            default:   ;
        endcase
    end

    assign cons_data      = prod_data;
    assign start_req_port = port_q;
    assign child_tag      = tag_q;
endmodule

// File: rtl/stream_port_hs_chk.sv
module stream_port_hs_chk #(
    parameter int PID_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prod_valid,
    input logic             prod_ready,
    input logic             cons_task_done,
    input logic             start_req,
    input logic [PID_W-1:0] start_req_port,
    input logic             start_ack,
    input logic             child_ready,
    input logic             port_busy,
    input logic             cons_valid,
    input logic             cons_ready,
    input logic             eos
);
    assert_req_port_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !cons_task_done) |=> (start_req && $stable(start_req_port)));

    assert_grant_needs_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_ack |-> $past(start_req && cons_task_done));

    assert_ack_marks_child_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_ack |-> (child_ready && port_busy));

    assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_ack |=> !start_ack);

    assert_no_early_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req || start_ack) |-> (!prod_ready && !cons_valid));

    assert_beat_coupled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_valid && cons_ready) |-> (prod_valid && prod_ready));

    assert_eos_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eos |=> !eos);

    assert_eos_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eos |-> (port_busy ##1 !port_busy));
endmodule

bind stream_port_hs stream_port_hs_chk #(.PID_W(PID_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .prod_valid     (prod_valid),
    .prod_ready     (prod_ready),
    .cons_task_done (cons_task_done),
    .start_req      (start_req),
    .start_req_port (start_req_port),
    .start_ack      (start_ack),
    .child_ready    (child_ready),
    .port_busy      (port_busy),
    .cons_valid     (cons_valid),
    .cons_ready     (cons_ready),
    .eos            (eos)
);

// File: tb/stream_port_hs_tb_top.sv
module stream_port_hs_tb_top;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 16;
    localparam int PID_W  = 4;
    localparam int TAG_W  = 4;
    localparam int BB     = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              prod_valid = 1'b0;
    logic              prod_ready;
    logic [DATA_W-1:0] prod_data = '0;
    logic [LEN_W-1:0]  prod_len = '0;
    logic [PID_W-1:0]  prod_port_id = '0;
    logic [TAG_W-1:0]  dep_dist = '0;
    logic              cons_task_done = 1'b0;
    logic              start_req;
    logic [PID_W-1:0]  start_req_port;
    logic              start_ack;
    logic              child_ready;
    logic [TAG_W-1:0]  child_tag;
    logic              port_busy;
    logic              cons_valid;
    logic              cons_ready = 1'b1;
    logic [DATA_W-1:0] cons_data;
    logic              eos;

    int n_chk  = 0;
    int n_fail = 0;
    int grants = 0;
    bit done   = 1'b0;

    logic [DATA_W-1:0] beat_q[$];
    logic [TAG_W-1:0]  tag_q[$];

    always #4 clk = ~clk;

    stream_port_hs #(.DATA_W(DATA_W), .LEN_W(LEN_W), .PID_W(PID_W), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .prod_valid(prod_valid), .prod_ready(prod_ready),
        .prod_data(prod_data), .prod_len(prod_len), .prod_port_id(prod_port_id),
        .dep_dist(dep_dist), .cons_task_done(cons_task_done), .start_req(start_req),
        .start_req_port(start_req_port), .start_ack(start_ack), .child_ready(child_ready),
        .child_tag(child_tag), .port_busy(port_busy), .cons_valid(cons_valid),
        .cons_ready(cons_ready), .cons_data(cons_data), .eos(eos)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compares accepted beats and child tags against the scoreboard queues
    always @(negedge clk) begin
        if (rst_n && cons_valid && cons_ready) begin
            if (beat_q.size() == 0) chk(1'b0, "R7 extra beat", 1, 0);
            else begin
                logic [DATA_W-1:0] e;
                e = beat_q.pop_front();
                chk(cons_data == e, "R6 cons_data", cons_data, e);
            end
        end
        if (rst_n && child_ready) begin
            if (tag_q.size() == 0) chk(1'b0, "R4 unexpected child_ready", 1, 0);
            else begin
                logic [TAG_W-1:0] t;
                t = tag_q.pop_front();
                chk(child_tag == t, "R10 child_tag", child_tag, t);
            end
        end
    end

    task automatic run_stream(input int len, input int dep, input int pid,
                              input int wait_cyc, input bit stall, input logic [DATA_W-1:0] base);
        int nbeats = (len + BB - 1) / BB;
        int i = 0;
        int cyc = 0;
        for (int j = 0; j < nbeats; j++) beat_q.push_back(base + DATA_W'(j));
        tag_q.push_back(TAG_W'(grants + dep));
        grants++;
        @(posedge clk); #1;
        prod_valid = 1'b1; prod_data = base; prod_len = LEN_W'(len);
        prod_port_id = PID_W'(pid); dep_dist = TAG_W'(dep); cons_ready = 1'b1;
        @(negedge clk);
        chk(start_req == 1'b0, "R2 no request while idle", start_req, 0);
        @(negedge clk);
        chk(start_req == 1'b1, "R2 start_req raised", start_req, 1);
        chk(start_req_port == PID_W'(pid), "R2 start_req_port", start_req_port, pid);
        chk(!prod_ready && !cons_valid, "R5 held before grant", prod_ready, 0);
        for (int k = 0; k < wait_cyc; k++) begin
            @(posedge clk); #1;
            prod_port_id = ~PID_W'(pid);
            @(negedge clk);
            chk(start_req && !start_ack, "R3 retried without done", start_ack, 0);
            chk(!prod_ready, "R5 no data while pending", prod_ready, 0);
        end
        @(posedge clk); #1; cons_task_done = 1'b1;
        @(negedge clk);
        @(posedge clk); #1; cons_task_done = 1'b0;
        @(negedge clk);
        chk(start_ack && child_ready, "R4 ack and child_ready", start_ack, 1);
        chk(port_busy == 1'b1, "R4 port busy on grant", port_busy, 1);
        if (len == 0) begin
            @(posedge clk); #1; prod_valid = 1'b0;
            @(negedge clk);
            chk(eos == 1'b1, "R9 eos right after grant", eos, 1);
            chk(prod_ready == 1'b0, "R9 no beat accepted", prod_ready, 0);
        end else begin
            while (i < nbeats) begin
                @(posedge clk); #1;
                prod_data  = base + DATA_W'(i);
                cons_ready = stall ? cyc[0] : 1'b1;
                cyc++;
                @(negedge clk);
                chk(cons_valid == prod_valid && prod_ready == cons_ready, "R6 pass-through",
                    prod_ready, cons_ready);
                chk(eos == 1'b0, "R7 no early eos", eos, 0);
                if (prod_ready) i++;
            end
            @(posedge clk); #1; prod_valid = 1'b0; cons_ready = 1'b1;
            @(negedge clk);
            chk(eos == 1'b1, "R7 eos after last beat", eos, 1);
            chk(port_busy == 1'b1, "R8 busy through eos", port_busy, 1);
        end
        @(negedge clk);
        chk(port_busy == 1'b0, "R8 port released", port_busy, 0);
        chk(eos == 1'b0 && start_req == 1'b0, "R1 back to idle", eos, 0);
        chk(beat_q.size() == 0, "R7 beat count", beat_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!start_req && !start_ack && !child_ready && !port_busy, "R1 reset outputs", port_busy, 0);
        chk(!prod_ready && !cons_valid && !eos, "R1 reset data outputs", prod_ready, 0);
        run_stream(8,  1,  3, 0, 1'b0, 32'h1000);
        run_stream(10, 3,  5, 3, 1'b1, 32'h2000);
        run_stream(0,  2,  7, 1, 1'b0, 32'h3000);
        run_stream(1,  0,  9, 1, 1'b0, 32'h4000);
        run_stream(16, 15, 12, 2, 1'b1, 32'h5000);
        chk(tag_q.size() == 0, "R10 all tags seen", tag_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule